// File: doc/BRIEF.md
# Masked Control Register with Atomic Write Aliases

This block holds one 64-bit control and status word on a register bus that moves only whole 8-byte words. Software reaches it through three word addresses. One writes the word directly. One merges the write data into the current value with an OR. The third is a destructive alias whose behaviour a build parameter picks. In one variant it ANDs the write data into the current value. In the other it zeroes the word whatever the data. With these aliases, software can set or drop single bits in one bus cycle and needs no read-modify-write.

Only the sixteen most significant bits are stored; the lower 48 always read as zero. The top bit drives a level-sensitive interrupt line straight from the stored value, so the line follows every write. Any access that decodes to no mapped word is refused. Such an access leaves the word alone, returns zero if it is a read, and raises a one-cycle error pulse.

Top module: `misc_alias_reg`

## Requirements
- R1: While reset is held and on the first cycle after it is released, the stored word is zero, `irqOut` is low, and `busRvalid`, `busErr` and `busRdata` are all zero.
- R2: An accepted write to the direct word stores bits 63..48 of the write data, and bits 47..0 are dropped. An accepted read of the direct word returns the stored value on `busRdata` with `busRvalid` high in the next cycle. In every other cycle `busRvalid` is low and `busRdata` is zero.
- R3: With `CLR_ALIAS` = 0, a write to word 0x4021 stores the current value ANDed with the write data, masked to bits 63..48.
- R4: A write to the OR word (0x4022 when `CLR_ALIAS` = 0, 0x6082 when it is 1) stores the current value ORed with the write data, masked to bits 63..48.
- R5: With `CLR_ALIAS` = 1, a write to word 0x6081 sets the stored word to zero whatever the write data.
- R6: `irqOut` equals bit 63 of the stored word. It changes only on the clock edge that accepts a write to a mapped word, and it holds steady otherwise.
- R7: An access whose byte address has bits 2..0 nonzero, or whose word (byte address shifted right by 3) is not one of the three mapped words, leaves the stored word unchanged. A read of that kind returns zero.
- R8: `busErr` is high for exactly the one cycle after an accepted access of the kind described in R7, and low in every other cycle.
- R9: A read of either alias word returns zero with `busRvalid` high, and it raises no error.
- R10: `CLR_ALIAS` = 0 maps the direct, AND and OR words to 0x4020, 0x4021 and 0x4022. `CLR_ALIAS` = 1 maps the direct, clear and OR words to 0x6080, 0x6081 and 0x6082. The words of the other variant count as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| busValid | input | 1 | Access request, accepted in the cycle it is high |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, one cycle after the read |
| busRvalid | output | 1 | Read data valid, one cycle after the read |
| busErr | output | 1 | One-cycle pulse after an unmapped access |
| irqOut | output | 1 | Level interrupt, bit 63 of the stored word |

## Verification
The assertions assume that `busWrite`, `busAddr` and `busWdata` hold known values whenever `busValid` is high. They also assume that reset is driven from time zero. The bench drives every input to a defined value before the first clock edge and changes inputs only on the falling edge. Its random phase draws addresses only from the mapped words of both variants, their misaligned byte addresses and one unused word. Both variants get the same stimulus, so each one sees the other's words as unmapped traffic.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;

  // Strobes from the decoder to the datapath, valid in the cycle of the access.
  typedef struct packed {
    logic wrDirect;
    logic wrAnd;
    logic wrOr;
    logic wrClr;
    logic rdDirect;
    logic rdAny;
    logic unmapped;
  } ctrl_t;

  // First word offset of the three-word window for each variant.
  function automatic int unsigned windowBase(input bit clrAlias);
    return clrAlias ? 32'h6080 : 32'h4020;
  endfunction

endpackage

// File: rtl/misc_alias_ctrl.sv
module misc_alias_ctrl
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter bit CLR_ALIAS = 1'b0
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrl_t             strb
);
  localparam int          WORD_W = ADDR_W - 3;
  localparam int unsigned BASE   = windowBase(CLR_ALIAS);
  localparam logic [WORD_W-1:0] OFF_DIRECT = WORD_W'(BASE);
  localparam logic [WORD_W-1:0] OFF_ALT    = WORD_W'(BASE + 1);
  localparam logic [WORD_W-1:0] OFF_OR     = WORD_W'(BASE + 2);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              hitDirect, hitAlt, hitOr, hitAny;
  logic              doWrite, doRead;

  assign word      = busAddr[ADDR_W-1:3];
  assign aligned   = (busAddr[2:0] == 3'b000);
  assign hitDirect = aligned && (word == OFF_DIRECT);
  assign hitAlt    = aligned && (word == OFF_ALT);
  assign hitOr     = aligned && (word == OFF_OR);
  assign hitAny    = hitDirect || hitAlt || hitOr;
  assign doWrite   = busValid && busWrite;
  assign doRead    = busValid && !busWrite;

  always_comb begin
    strb.wrDirect = doWrite && hitDirect;
    strb.wrOr     = doWrite && hitOr;
    strb.rdDirect = doRead && hitDirect;
    strb.rdAny    = doRead;
    strb.unmapped = busValid && !hitAny;
  end

  // The middle word is either an AND merge or an unconditional clear.
  generate
    if (CLR_ALIAS) begin : g_clr
      always_comb begin
        strb.wrClr = doWrite && hitAlt;
        strb.wrAnd = 1'b0;
      end
    end else begin : g_and
      always_comb begin
        strb.wrAnd = doWrite && hitAlt;
        strb.wrClr = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/misc_alias_dp.sv
module misc_alias_dp
  import misc_alias_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              busErr,
  output logic              irqOut
);
  localparam int LOW_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] keepQ, keepD;
  logic [KEEP_W-1:0] wHigh;
  logic [DATA_W-1:0] rdataQ;
  logic              rvalidQ, errQ;
  logic              unusedLow;

  assign wHigh     = busWdata[DATA_W-1:LOW_W];
  assign unusedLow = ^busWdata[LOW_W-1:0];

  always_comb begin
    keepD = keepQ;
    if (strb.wrDirect) keepD = wHigh;
    if (strb.wrAnd)    keepD = keepQ & wHigh;
    if (strb.wrOr)     keepD = keepQ | wHigh;
    if (strb.wrClr)    keepD = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keepQ   <= '0;
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      keepQ   <= keepD;
      rdataQ  <= strb.rdDirect ? {keepQ, {LOW_W{1'b0}}} : '0;
      rvalidQ <= strb.rdAny;
      errQ    <= strb.unmapped;
    end
  end

  assign busRdata  = rdataQ;
  assign busRvalid = rvalidQ;
  assign busErr    = errQ;
  assign irqOut    = keepQ[KEEP_W-1];

endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 64,
  parameter int KEEP_W    = 16,
  parameter bit CLR_ALIAS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              busErr,
  output logic              irqOut
);
  ctrl_t strb;

  misc_alias_ctrl #(
    .ADDR_W   (ADDR_W),
    .CLR_ALIAS(CLR_ALIAS)
  ) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strb)
  );

  misc_alias_dp #(
    .DATA_W(DATA_W),
    .KEEP_W(KEEP_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busRvalid(busRvalid),
    .busErr   (busErr),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/misc_alias_chk.sv
module misc_alias_chk
  import misc_alias_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 64,
  parameter bit CLR_ALIAS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busRvalid,
  input logic              busErr,
  input logic              irqOut
);
  localparam int unsigned BASE = windowBase(CLR_ALIAS);
  localparam logic [ADDR_W-1:0] BYTE_DIRECT = ADDR_W'(BASE << 3);
  localparam logic [ADDR_W-1:0] BYTE_ALT    = ADDR_W'((BASE + 1) << 3);
  localparam logic [ADDR_W-1:0] BYTE_OR     = ADDR_W'((BASE + 2) << 3);

  logic unusedRdata;
  assign unusedRdata = ^busRdata;

  p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busWrite) |=> busRvalid);

  p_no_rvalid_otherwise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busValid && !busWrite) |=> !busRvalid);

  p_direct_sets_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite && busAddr == BYTE_DIRECT) |=> (irqOut == $past(busWdata[DATA_W-1])));

  p_or_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && busWrite && busAddr == BYTE_OR && busWdata[DATA_W-1]) |=> irqOut);

  p_clear_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CLR_ALIAS && busValid && busWrite && busAddr == BYTE_ALT) |=> !irqOut);

  p_irq_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busValid && busWrite) |=> $stable(irqOut));

  p_unmapped_keeps_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> $stable(irqOut));

  p_err_needs_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |=> !busErr);

endmodule

bind misc_alias_reg misc_alias_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CLR_ALIAS(CLR_ALIAS)
) u_chk (.*);

// File: tb/misc_alias_reg_bench.sv
`timescale 1ns/1ps
module misc_alias_reg_bench;
  localparam int ADDR_W = 20;
  localparam logic [63:0] KEEP_MASK = 64'hFFFF_0000_0000_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [63:0]       busWdata = '0;

  logic [63:0] rdata0, rdata1;
  logic        rvalid0, rvalid1, err0, err1, irq0, irq1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Behavioural model, index 0 = AND variant, 1 = clear variant.
  logic [63:0] mdl [2];
  logic [63:0] expRdata [2];
  logic        expRvalid [2];
  logic        expErr [2];
  string       curReq;

  always #2 clk = ~clk;

  misc_alias_reg #(.ADDR_W(ADDR_W), .CLR_ALIAS(1'b0)) u_misc_alias_reg (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdata0),
    .busRvalid(rvalid0), .busErr(err0), .irqOut(irq0));

  misc_alias_reg #(.ADDR_W(ADDR_W), .CLR_ALIAS(1'b1)) u_misc_alias_reg_clr (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdata1),
    .busRvalid(rvalid1), .busErr(err1), .irqOut(irq1));

  function automatic logic [ADDR_W-1:0] wa(input int unsigned word);
    return ADDR_W'(word << 3);
  endfunction

  // 0 direct, 1 middle alias, 2 OR alias, 3 unmapped
  function automatic int kindOf(input int v, input logic [ADDR_W-1:0] a);
    int unsigned base = (v == 1) ? 32'h6080 : 32'h4020;
    int unsigned w = 32'(a >> 3);
    if (a[2:0] != 3'b000) return 3;
    if (w == base)     return 0;
    if (w == base + 1) return 1;
    if (w == base + 2) return 2;
    return 3;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("v0 irq (R6)", 64'(irq0), 64'(mdl[0][63]));
    chk("v1 irq (R6)", 64'(irq1), 64'(mdl[1][63]));
    chk("v0 rvalid", 64'(rvalid0), 64'(expRvalid[0]));
    chk("v1 rvalid", 64'(rvalid1), 64'(expRvalid[1]));
    chk("v0 rdata", rdata0, expRdata[0]);
    chk("v1 rdata", rdata1, expRdata[1]);
    chk("v0 err (R8)", 64'(err0), 64'(expErr[0]));
    chk("v1 err (R8)", 64'(err1), 64'(expErr[1]));
  endtask

  // Drive at the falling edge, update model, compare at the next falling edge.
  task automatic step(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                      input logic [63:0] d, input string req);
    curReq   = req;
    busValid = v;
    busWrite = w;
    busAddr  = a;
    busWdata = d;
    for (int i = 0; i < 2; i++) begin
      int k = kindOf(i, a);
      expRvalid[i] = v && !w;
      expErr[i]    = v && (k == 3);
      expRdata[i]  = (v && !w && k == 0) ? mdl[i] : 64'h0;
      if (v && w) begin
        case (k)
          0: mdl[i] = d & KEEP_MASK;
          1: mdl[i] = (i == 0) ? (mdl[i] & d & KEEP_MASK) : 64'h0;
          2: mdl[i] = (mdl[i] | d) & KEEP_MASK;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      mdl[i] = '0; expRdata[i] = '0; expRvalid[i] = 1'b0; expErr[i] = 1'b0;
    end
    curReq = "R1";
    repeat (3) @(negedge clk);
    compareAll();                       // R1 during reset
    rst_n = 1'b1;
    step(1'b0, 1'b0, '0, '0, "R1");     // R1 first cycle after release

    step(1, 1, wa('h4020), 64'hFFFF_FFFF_FFFF_FFFF, "R2 R7 R10");
    step(1, 0, wa('h4020), 64'h0, "R2");
    step(1, 1, wa('h6080), 64'h8001_1234_5678_9ABC, "R2 R10");
    step(1, 0, wa('h6080), 64'h0, "R2");
    step(1, 1, wa('h4021), 64'h7F00_FFFF_0000_0000, "R3 R6");
    step(1, 0, wa('h4020), 64'h0, "R3");
    step(1, 1, wa('h6082), 64'h0010_0000_0000_0001, "R4");
    step(1, 0, wa('h6080), 64'h0, "R4");
    step(1, 1, wa('h6081), 64'hFFFF_FFFF_FFFF_FFFF, "R5 R6");
    step(1, 0, wa('h6080), 64'h0, "R5");
    step(1, 1, wa('h4022), 64'h8000_0000_0000_0000, "R4 R6");
    step(1, 0, wa('h4021), 64'h0, "R9");
    step(1, 0, wa('h4022), 64'h0, "R9");
    step(1, 0, wa('h6081), 64'h0, "R9");
    step(1, 0, wa('h6082), 64'h0, "R9");
    step(1, 1, wa('h4020) | 20'h4, 64'h0, "R7 R8");
    step(1, 0, wa('h4020) | 20'h1, 64'h0, "R7 R8");
    step(1, 0, wa('h5000), 64'h0, "R7 R8");
    step(1, 1, wa('h5000), 64'h0, "R7 R8");
    step(0, 1, wa('h4020), 64'h0, "R6");
    step(0, 0, wa('h4020), 64'h0, "R6");
    step(1, 1, wa('h4021), 64'h0, "R3");
    step(1, 0, wa('h4020), 64'h0, "R3");

    for (int n = 0; n < 400; n++) begin
      int unsigned pick = $urandom_range(0, 8);
      logic [ADDR_W-1:0] a;
      logic [63:0] d = {$urandom, $urandom};
      case (pick)
        0: a = wa('h4020);
        1: a = wa('h4021);
        2: a = wa('h4022);
        3: a = wa('h6080);
        4: a = wa('h6081);
        5: a = wa('h6082);
        6: a = wa('h4021) | 20'h2;
        7: a = wa('h6082) | 20'h7;
        default: a = wa('h1234);
      endcase
      step(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)), a, d, "R2..mix R10");
    end
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule